// File: doc/BRIEF.md
# Paired FIFO Buffer with Sticky Event Flags

This block holds two data queues between a register-bus side and a serial-engine side. The outbound queue is filled by bus writes and drained by the serial engine. The inbound queue is filled by the serial engine and drained by bus reads. Each queue reports how many entries it holds. Simple one-cycle strobes stand in for the bus decoder and for the shifter.

Level and edge conditions on each queue latch into a set of sticky event flags, which are cleared by writing 1. The conditions are: below or above a programmable threshold, empty or full, and overrun or underrun. A smaller set of wake flags latches the four level conditions. Each flag set is masked by its own enable vector to drive one interrupt line or one wake line. DMA request lines follow the threshold conditions. A flush input empties a queue and wipes its pending flags.

The outbound threshold condition fires while the queue is short of data. The inbound threshold condition fires while the queue holds too much. A DMA engine can therefore refill one queue and drain the other from the same kind of request line.

Top module: `xfer_fifo_hub`

## Requirements
- R1: The outbound queue returns bus-written words to the serial side in write order. `tx_level` counts entries and changes on the clock edge that takes a push or a pop. `ser_rdata` shows the oldest entry while the queue is not empty, and that entry leaves on the edge where `ser_pop` is high.
- R2: The inbound queue returns serial-written words to the bus side in order. It uses the same rules through `ser_push`, `bus_rd`, `bus_rdata` and `rx_level`.
- R3: A push into a full queue (level equal to DEPTH) is dropped and leaves the level unchanged. It sets flag bit 12 for the outbound queue or flag bit 14 for the inbound queue on that edge.
- R4: A pop from an empty queue reads zero and leaves the queue unchanged. It sets flag bit 13 for the outbound queue or flag bit 15 for the inbound queue on that edge.
- R5: Flag bit 0 is set on each edge where `tx_level` is below `tx_thresh`. Flag bit 1 is set on each edge where `tx_level` is zero.
- R6: Flag bit 2 is set on each edge where `rx_level` is above `rx_thresh`. Flag bit 3 is set on each edge where `rx_level` equals DEPTH.
- R7: Flags stay set until a 1 arrives on the matching bit of `flag_clr`. When a set condition and a clear arrive on the same edge, the flag stays set.
- R8: A pulse on `tx_flush` or `rx_flush` empties that queue. On the same edge it clears that queue's flags (bits 0, 1, 12 and 13 for outbound; bits 2, 3, 14 and 15 for inbound) and its wake flags.
- R9: Wake flags bits 0 to 3 latch the same four conditions as flag bits 0 to 3. They are cleared through `wake_clr` with the set winning, and they are independent of the interrupt flags. `wake` is high when any wake flag that is enabled in `wake_en` is set.
- R10: `irq` is high exactly when some bit is set in both `int_flags` and `int_en`.
- R11: `tx_dma_req` is `tx_dma_en` ANDed with the live outbound threshold condition. `rx_dma_req` is `rx_dma_en` ANDed with the live inbound threshold condition. Dropping an enable removes the request at once.
- R12: Flag bits 4 to 11 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus push strobe into the outbound queue |
| bus_wdata | input | DW | Bus push data |
| bus_rd | input | 1 | Bus pop strobe from the inbound queue |
| bus_rdata | output | DW | Oldest inbound entry, zero when empty |
| ser_pop | input | 1 | Serial pop strobe from the outbound queue |
| ser_rdata | output | DW | Oldest outbound entry, zero when empty |
| ser_push | input | 1 | Serial push strobe into the inbound queue |
| ser_wdata | input | DW | Serial push data |
| tx_flush | input | 1 | Empty the outbound queue and wipe its flags |
| rx_flush | input | 1 | Empty the inbound queue and wipe its flags |
| tx_thresh | input | THR_W | Outbound low-water threshold |
| rx_thresh | input | THR_W | Inbound high-water threshold |
| flag_clr | input | 16 | Write-1-to-clear strobe for `int_flags` |
| int_en | input | 16 | Interrupt enable mask |
| wake_clr | input | 4 | Write-1-to-clear strobe for `wake_flags` |
| wake_en | input | 4 | Wake enable mask |
| tx_dma_en | input | 1 | Outbound DMA request enable |
| rx_dma_en | input | 1 | Inbound DMA request enable |
| tx_level | output | LVL_W | Outbound entry count |
| rx_level | output | LVL_W | Inbound entry count |
| int_flags | output | 16 | Sticky event flags |
| wake_flags | output | 4 | Sticky wake flags |
| irq | output | 1 | Masked OR of event flags |
| wake | output | 1 | Masked OR of wake flags |
| tx_dma_req | output | 1 | Outbound DMA request |
| rx_dma_req | output | 1 | Inbound DMA request |

## Verification
Results arrive at different times after a stimulus:
- Read data is visible in the cycle a pop is strobed.
- Levels and the overrun and underrun flags change on the edge that takes the strobe.
- Threshold, empty and full flags follow one edge later, because they are computed from the registered level.
- The DMA, interrupt and wake outputs follow their inputs within the same cycle.

The bench drives every input 1 ns after a rising edge and samples on the falling edge. Each check waits the number of edges its result needs: one extra edge for level-derived flags and none for event flags. A scoreboard queue compares every popped word against the order in which words were pushed.

// File: rtl/xfh_pkg.sv
package xfh_pkg;
    localparam int FLAG_W = 16;
    localparam int WAKE_W = 4;

    localparam int B_TX_THR  = 0;
    localparam int B_TX_EMP  = 1;
    localparam int B_RX_THR  = 2;
    localparam int B_RX_FULL = 3;
    localparam int B_TX_OV   = 12;
    localparam int B_TX_UN   = 13;
    localparam int B_RX_OV   = 14;
    localparam int B_RX_UN   = 15;

    localparam logic [FLAG_W-1:0] TX_GROUP = 16'h3003;
    localparam logic [FLAG_W-1:0] RX_GROUP = 16'hC00C;

    // Conditions and events produced by one queue per cycle.
    typedef struct packed {
        logic thr;
        logic lvl_edge;
        logic ovr;
        logic unr;
    } q_evt_t;

    function automatic logic [FLAG_W-1:0] pack_flags(q_evt_t tx, q_evt_t rx);
        logic [FLAG_W-1:0] v;
        v            = '0;
        v[B_TX_THR]  = tx.thr;
        v[B_TX_EMP]  = tx.lvl_edge;
        v[B_RX_THR]  = rx.thr;
        v[B_RX_FULL] = rx.lvl_edge;
        v[B_TX_OV]   = tx.ovr;
        v[B_TX_UN]   = tx.unr;
        v[B_RX_OV]   = rx.ovr;
        v[B_RX_UN]   = rx.unr;
        return v;
    endfunction
endpackage

// File: rtl/xfh_queue.sv
module xfh_queue #(
    parameter int DW    = 8,
    parameter int DEPTH = 32,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [DW-1:0]    wdata,
    input  logic             pop,
    output logic [DW-1:0]    rdata,
    output logic [LVL_W-1:0] level,
    output logic             overrun,
    output logic             underrun
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DW-1:0] store [DEPTH];
    logic [AW-1:0] wr_idx, rd_idx;
    logic full, empty, take_in, take_out;

    assign full     = (level == LVL_W'(DEPTH));
    assign empty    = (level == '0);
    assign take_in  = push && !full && !flush;
    assign take_out = pop && !empty && !flush;
    assign overrun  = push && full && !flush;
    assign underrun = pop && empty && !flush;
    assign rdata    = empty ? '0 : store[rd_idx];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_idx <= '0;
            rd_idx <= '0;
            level  <= '0;
        end else begin
            if (take_in)
                wr_idx <= (wr_idx == LAST) ? '0 : wr_idx + 1'b1;
            if (take_out)
                rd_idx <= (rd_idx == LAST) ? '0 : rd_idx + 1'b1;
            case ({take_in, take_out})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (take_in)
            store[wr_idx] <= wdata;
    end
endmodule

// File: rtl/xfh_sticky.sv
module xfh_sticky #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    input  logic [W-1:0] wipe,
    output logic [W-1:0] q
);
    // A set beats a write-1 clear; a flush wipe beats both.
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= ((q & ~clr) | set) & ~wipe;
    end
endmodule

// File: rtl/xfer_fifo_hub.sv
module xfer_fifo_hub
    import xfh_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 32,
    parameter int THR_W = 5,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              bus_rd,
    output logic [DW-1:0]     bus_rdata,
    input  logic              ser_pop,
    output logic [DW-1:0]     ser_rdata,
    input  logic              ser_push,
    input  logic [DW-1:0]     ser_wdata,
    input  logic              tx_flush,
    input  logic              rx_flush,
    input  logic [THR_W-1:0]  tx_thresh,
    input  logic [THR_W-1:0]  rx_thresh,
    input  logic [15:0]       flag_clr,
    input  logic [15:0]       int_en,
    input  logic [3:0]        wake_clr,
    input  logic [3:0]        wake_en,
    input  logic              tx_dma_en,
    input  logic              rx_dma_en,
    output logic [LVL_W-1:0]  tx_level,
    output logic [LVL_W-1:0]  rx_level,
    output logic [15:0]       int_flags,
    output logic [3:0]        wake_flags,
    output logic              irq,
    output logic              wake,
    output logic              tx_dma_req,
    output logic              rx_dma_req
);
    q_evt_t tx_evt, rx_evt;
    logic tx_ovr, tx_unr, rx_ovr, rx_unr;
    logic [FLAG_W-1:0] flag_set, flag_wipe;
    logic [WAKE_W-1:0] wake_wipe;

    xfh_queue #(.DW(DW), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_txq (
        .clk(clk), .rst(rst), .flush(tx_flush),
        .push(bus_wr), .wdata(bus_wdata),
        .pop(ser_pop), .rdata(ser_rdata),
        .level(tx_level), .overrun(tx_ovr), .underrun(tx_unr)
    );

    xfh_queue #(.DW(DW), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_rxq (
        .clk(clk), .rst(rst), .flush(rx_flush),
        .push(ser_push), .wdata(ser_wdata),
        .pop(bus_rd), .rdata(bus_rdata),
        .level(rx_level), .overrun(rx_ovr), .underrun(rx_unr)
    );

    // Outbound fires while short of data, inbound while holding too much.
    always_comb begin
        tx_evt.thr      = 32'(tx_level) < 32'(tx_thresh);
        tx_evt.lvl_edge = (tx_level == '0);
        tx_evt.ovr      = tx_ovr;
        tx_evt.unr      = tx_unr;
        rx_evt.thr      = 32'(rx_level) > 32'(rx_thresh);
        rx_evt.lvl_edge = (rx_level == LVL_W'(DEPTH));
        rx_evt.ovr      = rx_ovr;
        rx_evt.unr      = rx_unr;
    end

    assign flag_set  = pack_flags(tx_evt, rx_evt);
    assign flag_wipe = (tx_flush ? TX_GROUP : '0) | (rx_flush ? RX_GROUP : '0);
    assign wake_wipe = {rx_flush, rx_flush, tx_flush, tx_flush};

    xfh_sticky #(.W(FLAG_W)) u_int_flags (
        .clk(clk), .rst(rst), .set(flag_set), .clr(flag_clr),
        .wipe(flag_wipe), .q(int_flags)
    );

    xfh_sticky #(.W(WAKE_W)) u_wake_flags (
        .clk(clk), .rst(rst), .set(flag_set[WAKE_W-1:0]), .clr(wake_clr),
        .wipe(wake_wipe), .q(wake_flags)
    );

    assign irq        = |(int_flags & int_en);
    assign wake       = |(wake_flags & wake_en);
    assign tx_dma_req = tx_dma_en && tx_evt.thr;
    assign rx_dma_req = rx_dma_en && rx_evt.thr;
endmodule

// File: rtl/xfh_checker.sv
module xfh_checker #(
    parameter int DEPTH = 32,
    parameter int THR_W = 5,
    parameter int LVL_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic             tx_flush,
    input logic             rx_flush,
    input logic [THR_W-1:0] tx_thresh,
    input logic [15:0]      int_en,
    input logic             tx_dma_en,
    input logic [LVL_W-1:0] tx_level,
    input logic [LVL_W-1:0] rx_level,
    input logic [15:0]      int_flags,
    input logic             irq,
    input logic             tx_dma_req
);
    assert_level_bound_R1: assert property (@(posedge clk) disable iff (rst)
        (32'(tx_level) <= DEPTH) && (32'(rx_level) <= DEPTH));

    assert_tx_overrun_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && 32'(tx_level) == DEPTH && !tx_flush) |=> int_flags[12]);

    assert_rx_underrun_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && rx_level == '0 && !rx_flush) |=> int_flags[15]);

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (32'(tx_level) < 32'(tx_thresh) && !tx_flush) |=> int_flags[0]);

    assert_flush_wipe_R8: assert property (@(posedge clk) disable iff (rst)
        tx_flush |=> (tx_level == '0 && int_flags[13:12] == 2'b00 && int_flags[1:0] == 2'b00));

    assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        ((int_flags & int_en) == 16'h0) |-> !irq);

    assert_dma_gate_R11: assert property (@(posedge clk) disable iff (rst)
        !tx_dma_en |-> !tx_dma_req);

    assert_reserved_zero_R12: assert property (@(posedge clk) disable iff (rst)
        int_flags[11:4] == 8'h00);
endmodule

bind xfer_fifo_hub xfh_checker #(.DEPTH(DEPTH), .THR_W(THR_W), .LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .tx_flush(tx_flush), .rx_flush(rx_flush), .tx_thresh(tx_thresh),
    .int_en(int_en), .tx_dma_en(tx_dma_en), .tx_level(tx_level),
    .rx_level(rx_level), .int_flags(int_flags), .irq(irq),
    .tx_dma_req(tx_dma_req)
);

// File: tb/xfer_fifo_hub_tb.sv
`timescale 1ns/1ps
module xfer_fifo_hub_tb;
    localparam int DW = 8;
    localparam int DEPTH = 32;
    localparam int THR_W = 5;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_wr = 0, bus_rd = 0, ser_pop = 0, ser_push = 0;
    logic [DW-1:0] bus_wdata = '0, ser_wdata = '0, bus_rdata, ser_rdata;
    logic tx_flush = 0, rx_flush = 0, tx_dma_en = 0, rx_dma_en = 0;
    logic [THR_W-1:0] tx_thresh = 5'd4, rx_thresh = 5'd2;
    logic [15:0] flag_clr = '0, int_en = '0, int_flags;
    logic [3:0] wake_clr = '0, wake_en = '0, wake_flags;
    logic [LVL_W-1:0] tx_level, rx_level;
    logic irq, wake, tx_dma_req, rx_dma_req;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] txq[$];
    logic [DW-1:0] rxq[$];

    always #2.5 clk = ~clk;

    xfer_fifo_hub #(.DW(DW), .DEPTH(DEPTH), .THR_W(THR_W)) u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic push_tx(input logic [DW-1:0] d);
        cyc();
        bus_wr = 1; bus_wdata = d;
        if (txq.size() < DEPTH) txq.push_back(d);
        cyc();
        bus_wr = 0;
    endtask

    task automatic pop_tx();
        cyc(); ser_pop = 1; cyc(); ser_pop = 0;
    endtask

    task automatic push_rx(input logic [DW-1:0] d);
        cyc();
        ser_push = 1; ser_wdata = d;
        if (rxq.size() < DEPTH) rxq.push_back(d);
        cyc();
        ser_push = 0;
    endtask

    task automatic pop_rx();
        cyc(); bus_rd = 1; cyc(); bus_rd = 0;
    endtask

    // Scoreboard monitor: every pop is compared with the oldest expected word.
    always @(negedge clk) begin
        if (!rst) begin
            if (ser_pop)
                chk("R1 tx order", 32'(ser_rdata),
                    32'(txq.size() > 0 ? txq.pop_front() : '0));
            if (bus_rd)
                chk("R2 rx order", 32'(bus_rdata),
                    32'(rxq.size() > 0 ? rxq.pop_front() : '0));
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("reset tx_level", 32'(tx_level), 0);
        chk("reset int_flags", 32'(int_flags), 0);
        chk("reset irq", 32'(irq), 0);
        cyc(); rst = 0;
        cyc(); cyc();
        @(negedge clk);
        chk("R5 tx thr+empty after reset", 32'(int_flags[1:0]), 2'b11);
        chk("R11 dma off", 32'(tx_dma_req), 0);
        cyc(); tx_dma_en = 1;
        @(negedge clk);
        chk("R11 tx dma req", 32'(tx_dma_req), 1);
        cyc(); tx_dma_en = 0;
        @(negedge clk);
        chk("R11 tx dma dropped", 32'(tx_dma_req), 0);

        for (int i = 0; i < 5; i++) push_tx(8'h11 + 8'(i));
        @(negedge clk);
        chk("R1 tx_level", 32'(tx_level), 5);
        chk("R7 sticky after condition gone", 32'(int_flags[1:0]), 2'b11);
        cyc(); flag_clr = 16'h0003; cyc(); flag_clr = '0;
        @(negedge clk);
        chk("R7 w1c clears", 32'(int_flags[1:0]), 0);
        for (int i = 0; i < 5; i++) pop_tx();
        pop_tx();
        @(negedge clk);
        chk("R4 tx underrun flag", 32'(int_flags[13]), 1);
        chk("R1 tx_level drained", 32'(tx_level), 0);
        cyc(); flag_clr = 16'h0001; cyc(); flag_clr = '0;
        @(negedge clk);
        chk("R7 set wins over clear", 32'(int_flags[0]), 1);

        for (int i = 0; i < DEPTH + 1; i++) push_tx(8'(8'hA0 + i));
        @(negedge clk);
        chk("R3 tx full level", 32'(tx_level), DEPTH);
        chk("R3 tx overrun flag", 32'(int_flags[12]), 1);
        cyc(); tx_flush = 1; cyc(); tx_flush = 0; txq.delete();
        @(negedge clk);
        chk("R8 flush level", 32'(tx_level), 0);
        chk("R8 flush wipes tx flags", 32'(int_flags & 16'h3003), 0);
        chk("R8 flush wipes tx wake", 32'(wake_flags[1:0]), 0);
        pop_tx();

        push_rx(8'h51); push_rx(8'h52); cyc();
        @(negedge clk);
        chk("R6 rx thr not at equal", 32'(int_flags[2]), 0);
        push_rx(8'h53); cyc();
        @(negedge clk);
        chk("R6 rx thr above", 32'(int_flags[2]), 1);
        cyc(); rx_dma_en = 1;
        @(negedge clk);
        chk("R11 rx dma req", 32'(rx_dma_req), 1);
        for (int i = 3; i < DEPTH + 1; i++) push_rx(8'(8'h60 + i));
        cyc();
        @(negedge clk);
        chk("R2 rx full level", 32'(rx_level), DEPTH);
        chk("R6 rx full flag", 32'(int_flags[3]), 1);
        chk("R3 rx overrun flag", 32'(int_flags[14]), 1);
        for (int i = 0; i < DEPTH + 1; i++) pop_rx();
        @(negedge clk);
        chk("R4 rx underrun flag", 32'(int_flags[15]), 1);
        cyc(); rx_dma_en = 0;
        @(negedge clk);
        chk("R11 rx dma dropped", 32'(rx_dma_req), 0);

        chk("R10 irq masked", 32'(irq), 0);
        cyc(); int_en = 16'h8000;
        @(negedge clk);
        chk("R10 irq enabled", 32'(irq), 1);
        cyc(); flag_clr = 16'h8000; cyc(); flag_clr = '0;
        @(negedge clk);
        chk("R10 irq after clear", 32'(irq), 0);

        chk("R9 wake masked", 32'(wake), 0);
        chk("R9 wake rx full latched", 32'(wake_flags[3]), 1);
        cyc(); wake_en = 4'b1000;
        @(negedge clk);
        chk("R9 wake enabled", 32'(wake), 1);
        cyc(); wake_clr = 4'b1000; cyc(); wake_clr = '0;
        @(negedge clk);
        chk("R9 wake cleared", 32'(wake_flags[3]), 0);
        chk("R9 wake line low", 32'(wake), 0);
        chk("R9 int flag independent", 32'(int_flags[3]), 1);
        chk("R12 reserved bits", 32'(int_flags[11:4]), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule